// File: doc/BRIEF.md
# QPSK Symbol Mapper

This block turns two-bit symbols into signed fixed-point in-phase and quadrature samples. Each sample lies on one of four points spaced a quarter turn apart. The caller supplies one base point as the precomputed cosine and sine of the phase offset angle. That angle is the phase of the point selected by symbol zero. The block makes the other three points by swapping and negating those two components, so no trigonometry runs in hardware.

Symbols arrive in one of two forms, fixed at elaboration by a parameter. In integer mode each valid cycle carries a whole symbol from 0 to 3. In bit mode each valid cycle carries one bit, and bits are grouped into pairs with the earlier bit as the most significant. A second parameter chooses binary or Gray ordering of symbols around the circle.

A valid strobe qualifies the input side and the output side. The output is registered. There is no backpressure.

Top module: `qpsk_mapper`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `i_o` and `q_o` are 0. Any half-collected bit pair is discarded.
- R2: In integer mode (`BIT_IN`=0), a symbol `data_i` accepted with `valid_i` high produces `valid_o` high on the following cycle. `valid_o` is low in every other cycle.
- R3: With binary ordering (`GRAY`=0), symbol value m selects quarter-turn index k = m, so the point is at angle offset + m·π/2.
- R4: With Gray ordering (`GRAY`=1), symbol values 0, 1, 3 and 2 select quarter-turn indices 0, 1, 2 and 3 respectively.
- R5: For base point (c, s) = (`cos_i`, `sin_i`), index k gives (`i_o`, `q_o`) as follows: k=0 gives (c, s), k=1 gives (−s, c), k=2 gives (−c, −s) and k=3 gives (s, −c).
- R6: Negating the most negative code −2^(W−1) yields the most positive code 2^(W−1)−1, so the output never wraps.
- R7: In bit mode (`BIT_IN`=1), the bit is taken from `data_i[0]`. The first accepted bit of a pair is the symbol MSB and the second is the LSB. The output appears one cycle after the second bit. Idle cycles between the two bits do not break the pair.
- R8: In bit mode, a single unpaired bit never produces an output. After a reset, pairing restarts with the next accepted bit.
- R9: In cycles where `valid_o` is low, `i_o` and `q_o` keep their last values, whatever the inputs do.
- R10: `cos_i` and `sin_i` are sampled in the cycle that completes the symbol (the accepted symbol, or the second bit). With c = s ≈ 0.7071·2^FRAC, the four outputs form the diagonal constellation at odd multiples of π/4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input symbol or bit is valid |
| data_i | input | 2 | Symbol value (integer mode) or bit in bit 0 (bit mode) |
| cos_i | input | W | Cosine of phase offset, signed, FRAC fraction bits |
| sin_i | input | W | Sine of phase offset, signed, FRAC fraction bits |
| valid_o | output | 1 | Output sample valid |
| i_o | output | W | In-phase sample, signed |
| q_o | output | W | Quadrature sample, signed |

## Verification
The bench builds four copies with W=8 and FRAC=6, one for each pairing of input mode and ordering. The narrow word lets the integer-mode sweep take every one of the 256 cosine codes, each under all four symbols. That sweep reaches the most negative code at every quarter turn, which exercises the saturating negation.

The bit-mode copies are swept over a coarser grid of base points. They are also given split pairs, an orphan bit cleared by reset, and cosine and sine values that change between the two bits of a pair. A diagonal base point near 45 checks the π/4 case in both orderings.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;
  typedef logic [1:0] qsym_t;

  typedef enum logic [1:0] {
    TURN_0   = 2'd0,
    TURN_90  = 2'd1,
    TURN_180 = 2'd2,
    TURN_270 = 2'd3
  } qturn_e;
endpackage

// File: rtl/qpsk_pair_collector.sv
module qpsk_pair_collector
  import qpsk_pkg::*;
#(
  parameter bit BIT_IN = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  logic [1:0] data_i,
  output logic  sym_vld_o,
  output qsym_t sym_o,
  output logic  half_o
);
  if (BIT_IN) begin : g_bits
    logic half_q;
    logic hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        half_q <= 1'b0;
        hi_q   <= 1'b0;
      end else if (valid_i) begin
        if (!half_q) begin
          hi_q   <= data_i[0];
          half_q <= 1'b1;
        end else begin
          half_q <= 1'b0;
        end
      end
    end

    assign sym_vld_o = valid_i & half_q;
    assign sym_o     = {hi_q, data_i[0]};
    assign half_o    = half_q;
  end else begin : g_ints
    assign sym_vld_o = valid_i;
    assign sym_o     = data_i;
    assign half_o    = 1'b0;
  end
endmodule

// File: rtl/qpsk_sym_order.sv
module qpsk_sym_order
  import qpsk_pkg::*;
#(
  parameter bit GRAY = 1'b0
) (
  input  qsym_t  sym_i,
  output qturn_e turn_o
);
  if (GRAY) begin : g_gray
    // gray decode: adjacent turns differ in one bit
    assign turn_o = qturn_e'({sym_i[1], sym_i[1] ^ sym_i[0]});
  end else begin : g_bin
    assign turn_o = qturn_e'(sym_i);
  end
endmodule

// File: rtl/qpsk_rotator.sv
module qpsk_rotator
  import qpsk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] c_i,
  input  logic signed [W-1:0] s_i,
  input  qturn_e              turn_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

  function automatic logic signed [W-1:0] neg_sat(input logic signed [W-1:0] v);
    return (v == MIN_V) ? MAX_V : -v;
  endfunction

  logic signed [W-1:0] nc, ns;
  assign nc = neg_sat(c_i);
  assign ns = neg_sat(s_i);

  always_comb begin
    unique case (turn_i)
      TURN_0:   begin x_o = c_i; y_o = s_i; end
      TURN_90:  begin x_o = ns;  y_o = c_i; end
      TURN_180: begin x_o = nc;  y_o = ns;  end
      default:  begin x_o = s_i; y_o = nc;  end
    endcase
  end
endmodule

// File: rtl/qpsk_mapper.sv
module qpsk_mapper
  import qpsk_pkg::*;
#(
  parameter int W      = 16,
  parameter int FRAC   = 14,
  parameter bit BIT_IN = 1'b0,
  parameter bit GRAY   = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   data_i,
  input  logic [W-1:0] cos_i,
  input  logic [W-1:0] sin_i,
  output logic         valid_o,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o
);
  if (FRAC > W - 1) begin : g_bad_frac
    $error("FRAC must leave a sign bit");
  end

  logic   sym_vld;
  qsym_t  sym;
  logic   half_pair;
  qturn_e turn;
  logic signed [W-1:0] rx, ry;

  qpsk_pair_collector #(.BIT_IN(BIT_IN)) u_collect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .data_i   (data_i),
    .sym_vld_o(sym_vld),
    .sym_o    (sym),
    .half_o   (half_pair)
  );

  qpsk_sym_order #(.GRAY(GRAY)) u_order (
    .sym_i (sym),
    .turn_o(turn)
  );

  qpsk_rotator #(.W(W)) u_rot (
    .c_i   (cos_i),
    .s_i   (sin_i),
    .turn_i(turn),
    .x_o   (rx),
    .y_o   (ry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      i_o     <= '0;
      q_o     <= '0;
    end else begin
      valid_o <= sym_vld;
      if (sym_vld) begin
        i_o <= rx;
        q_o <= ry;
      end
    end
  end
endmodule

// File: rtl/qpsk_mapper_chk.sv
module qpsk_mapper_chk #(
  parameter int W      = 16,
  parameter bit BIT_IN = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] cos_i,
  input logic [W-1:0] sin_i,
  input logic         valid_o,
  input logic [W-1:0] i_o,
  input logic [W-1:0] q_o,
  input logic         half_i
);
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

  function automatic logic [W-1:0] mag(input logic [W-1:0] v);
    if (v == MIN_V) return MAX_V;
    return v[W-1] ? -v : v;
  endfunction

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (valid_o == 1'b0 && i_o == '0 && q_o == '0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !valid_o |-> ($stable(i_o) && $stable(q_o)));

  p_rot_mag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    valid_o |-> ((mag(i_o) == mag($past(cos_i)) && mag(q_o) == mag($past(sin_i))) ||
                 (mag(i_o) == mag($past(sin_i)) && mag(q_o) == mag($past(cos_i)))));

  p_no_min_from_neg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (valid_o && i_o == MIN_V) |-> ($past(cos_i) == MIN_V || $past(sin_i) == MIN_V));

  if (BIT_IN) begin : g_bit_chk
    p_pair_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      valid_o |-> ($past(valid_i) && $past(half_i)));

    p_no_b2b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      valid_o |=> !valid_o);
  end else begin : g_int_chk
    p_int_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      valid_o == $past(valid_i));
  end
endmodule

bind qpsk_mapper qpsk_mapper_chk #(.W(W), .BIT_IN(BIT_IN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .cos_i  (cos_i),
  .sin_i  (sin_i),
  .valid_o(valid_o),
  .i_o    (i_o),
  .q_o    (q_o),
  .half_i (half_pair)
);

// File: tb/test_qpsk_mapper.sv
module test_qpsk_mapper;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int FRAC  = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic         vi_int = 1'b0, vi_bit = 1'b0;
  logic [1:0]   d_int = '0, d_bit = '0;
  logic [W-1:0] cs = '0, sn = '0;

  logic         vo [4];
  logic [W-1:0] io [4];
  logic [W-1:0] qo [4];

  // 0: int/bin, 1: int/gray, 2: bit/bin, 3: bit/gray
  qpsk_mapper #(.W(W), .FRAC(FRAC), .BIT_IN(1'b0), .GRAY(1'b0)) i_qpsk_mapper (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(vi_int), .data_i(d_int),
    .cos_i(cs), .sin_i(sn), .valid_o(vo[0]), .i_o(io[0]), .q_o(qo[0]));
  qpsk_mapper #(.W(W), .FRAC(FRAC), .BIT_IN(1'b0), .GRAY(1'b1)) i_qpsk_mapper_ig (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(vi_int), .data_i(d_int),
    .cos_i(cs), .sin_i(sn), .valid_o(vo[1]), .i_o(io[1]), .q_o(qo[1]));
  qpsk_mapper #(.W(W), .FRAC(FRAC), .BIT_IN(1'b1), .GRAY(1'b0)) i_qpsk_mapper_bb (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(vi_bit), .data_i(d_bit),
    .cos_i(cs), .sin_i(sn), .valid_o(vo[2]), .i_o(io[2]), .q_o(qo[2]));
  qpsk_mapper #(.W(W), .FRAC(FRAC), .BIT_IN(1'b1), .GRAY(1'b1)) i_qpsk_mapper_bg (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(vi_bit), .data_i(d_bit),
    .cos_i(cs), .sin_i(sn), .valid_o(vo[3]), .i_o(io[3]), .q_o(qo[3]));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int neg(input int x);
    return (x == -(1 << (W-1))) ? (1 << (W-1)) - 1 : -x;
  endfunction

  function automatic int wrap(input int x);
    int m = x & ((1 << W) - 1);
    return (m >= (1 << (W-1))) ? m - (1 << W) : m;
  endfunction

  // R3 binary: k=m ; R4 gray: 0,1,3,2 -> 0,1,2,3 ; R5 rotation table
  task automatic expect_pt(input int c, input int s, input int sym, input bit gray,
                           output int ei, output int eq);
    int k;
    if (!gray) k = sym;
    else k = (sym == 0) ? 0 : (sym == 1) ? 1 : (sym == 3) ? 2 : 3;
    case (k)
      0: begin ei = c;      eq = s;      end
      1: begin ei = neg(s); eq = c;      end
      2: begin ei = neg(c); eq = neg(s); end
      default: begin ei = s; eq = neg(c); end
    endcase
  endtask

  task automatic cmp_out(input int idx, input string req, input int c, input int s,
                         input int sym, input bit gray);
    int ei, eq;
    expect_pt(c, s, sym, gray, ei, eq);
    chk({req, " valid"}, int'(vo[idx]), 1);
    chk({req, " i"}, int'($signed(io[idx])), ei);
    chk({req, " q"}, int'($signed(qo[idx])), eq);
  endtask

  // bit mode: MSB, optional gap, LSB with base point changed on the LSB cycle
  task automatic send_pair(input int sym, input bit gap, input int c, input int s);
    vi_bit = 1'b1; d_bit = {1'b0, sym[1]};
    cs = W'(c + 3); sn = W'(s - 5);
    @(negedge clk);
    chk("R8 no output on first bit bb", int'(vo[2]), 0);
    chk("R8 no output on first bit bg", int'(vo[3]), 0);
    if (gap) begin
      vi_bit = 1'b0; d_bit = 2'b01;
      @(negedge clk);
      chk("R7 no output in gap", int'(vo[2] | vo[3]), 0);
    end
    vi_bit = 1'b1; d_bit = {1'b1, sym[0]};
    cs = W'(c); sn = W'(s);
    @(negedge clk);
    vi_bit = 1'b0;
    cs = W'(c ^ 8'h55); sn = W'(~s);
    cmp_out(2, "R7 R10 bit bin", c, s, sym, 1'b0);
    cmp_out(3, "R7 R10 bit gray", c, s, sym, 1'b1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int li, lq;
    repeat (3) @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      chk("R1 reset valid", int'(vo[j]), 0);
      chk("R1 reset i", int'(io[j]), 0);
      chk("R1 reset q", int'(qo[j]), 0);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // integer sweep: every cosine code, all symbols, back to back
    for (int c = -(1 << (W-1)); c < (1 << (W-1)); c++) begin
      for (int m = 0; m < 4; m++) begin
        int s = wrap(c * 37 + 11 + m);
        vi_int = 1'b1; d_int = 2'(m); cs = W'(c); sn = W'(s);
        @(negedge clk);
        cmp_out(0, "R2 R3 R5 R6 int bin", c, s, m, 1'b0);
        cmp_out(1, "R2 R4 R5 R6 int gray", c, s, m, 1'b1);
      end
    end

    // R6 explicit: most negative at half turn
    vi_int = 1'b1; d_int = 2'd2; cs = 8'h80; sn = 8'h80;
    @(negedge clk);
    chk("R6 sat i", int'($signed(io[0])), 127);
    chk("R6 sat q", int'($signed(qo[0])), 127);

    // R9 hold, R2 no valid without input
    vi_int = 1'b0;
    li = int'($signed(io[1])); lq = int'($signed(qo[1]));
    for (int t = 0; t < 4; t++) begin
      d_int = 2'(t); cs = W'(t * 19); sn = W'(t * 7 + 1);
      @(negedge clk);
      chk("R2 R9 idle valid", int'(vo[1]), 0);
      chk("R9 hold i", int'($signed(io[1])), li);
      chk("R9 hold q", int'($signed(qo[1])), lq);
    end

    // R10 diagonal at pi/4: 0.7071*64 ~ 45
    for (int m = 0; m < 4; m++) begin
      int ei, eq;
      vi_int = 1'b1; d_int = 2'(m); cs = 8'd45; sn = 8'd45;
      @(negedge clk);
      for (int g = 0; g < 2; g++) begin
        expect_pt(45, 45, m, g[0], ei, eq);
        chk("R10 diag |i|", int'($signed(io[g])), ei);
        chk("R10 diag |q|", int'($signed(qo[g])), eq);
        chk("R10 diag mag", (ei < 0 ? -ei : ei) + (eq < 0 ? -eq : eq), 90);
      end
    end
    vi_int = 1'b0;
    @(negedge clk);

    // bit-mode sweep, some pairs split by an idle cycle
    for (int c = -(1 << (W-1)); c < (1 << (W-1)); c += 8) begin
      for (int m = 0; m < 4; m++) begin
        send_pair(m, m[0] ^ c[3], c, wrap(c * 5 - 9));
      end
    end

    // R8 orphan bit then reset: pairing restarts
    vi_bit = 1'b1; d_bit = 2'b01;
    @(negedge clk);
    vi_bit = 1'b0;
    chk("R8 orphan no output", int'(vo[2] | vo[3]), 0);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset clears valid", int'(vo[2]), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    send_pair(1, 1'b0, 30, -20);

    // R8 single bit alone stays silent
    vi_bit = 1'b1; d_bit = 2'b00;
    @(negedge clk);
    vi_bit = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 dangling bit silent", int'(vo[2] | vo[3]), 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule